// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that follows a chain of transfer descriptors stored in system memory. Software writes the address of the first descriptor and sets the run bit. The channel then reads four words: link, source, target and command. It copies the requested number of bytes one element at a time, reading from the source and writing to the target. When the descriptor is done it moves to the next one. A set stop bit in the link ends the chain. A link that points back to an earlier descriptor makes the channel loop for as long as software lets it run.

Transfers can be paced by a peripheral request line in units of a burst. Start, end and bus-error events set sticky flags that are cleared by writing ones, and any set flag drives the interrupt output. Software can read the live source and target pointers while the channel is running, which gives the progress of the current descriptor.

Top module: `dmac_channel`

## Requirements
- R1: After reset the channel is idle: control/status reads 0x0000_0008 (stopped bit 3 set, run bit 31 clear, flags 2:0 clear), `irq` is low, `mem_req` is low and the descriptor pointer reads zero.
- R2: Register map on `reg_addr`: 0 is the descriptor pointer, 1 is control/status, 2 is the current source and 3 is the current target. Registers 2 and 3 are read-only. Pointer bits 3:0 always read zero. Writes to the pointer are ignored while the channel runs.
- R3: Writing control/status with bit 31 set while stopped starts a fetch. The channel reads the words at pointer+0, +4, +8 and +12 as link, source, target and command. `mem_addr` and `mem_we` stay stable while `mem_req` waits for `mem_ack`.
- R4: Command bits 12:0 give the byte length. Bits 15:14 give the element size (1 = byte, 2 = halfword, 3 = word, 0 = word). Each element is a read at the source followed by a write at the target of min(element size, bytes left) bytes, reported on `mem_bytes`. Data is passed lane for lane.
- R5: Command bit 31 advances the source by each element's size and bit 30 advances the target; with the bit clear, that address is held.
- R6: A zero-length descriptor performs no data access but still completes, raising its enabled flags.
- R7: A link with bit 0 clear continues at the link with bits 3:0 zeroed, and a loop back repeats indefinitely. A completed descriptor whose link has bit 0 set clears run and sets stopped, leaving the pointer on that descriptor.
- R8: With command bit 29 or bit 28 set, each burst (bits 17:16: 2 = 16, 3 = 32, otherwise 8 bytes) begins only in a cycle where `periph_req` is high. Control/status bit 8 shows `periph_req`.
- R9: Flag bit 1 sets when a descriptor with command bit 22 begins. Flag bit 2 sets when a descriptor with command bit 21 completes. `irq` is high while any of flags 2:0 is set.
- R10: Writing control/status clears each flag whose written bit is one and leaves the others; an event in the same cycle keeps its flag set.
- R11: `mem_err` returned with `mem_ack` sets flag bit 0 and stops the channel (run clear, stopped set) with no further access.
- R12: Writing control/status with bit 31 clear while running stops the channel at the next element boundary, after which no access is made. Flag clears during a run must therefore keep bit 31 set.
- R13: Registers 2 and 3 show the source and target advancing element by element during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_bytes | output | 3 | Bytes in the access (1, 2 or 4) |
| mem_wdata | output | 32 | Write data, lanes as read |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |
| periph_req | input | 1 | Peripheral ready for a burst |
| irq | output | 1 | Any flag set |

## Verification
The bench builds the block with the package defaults: a 13-bit length counter, three element sizes and bursts of up to 32 bytes. It also uses a 1 KiB memory model with pseudo-random acknowledge stalls and an error window above it. At these sizes the bench can sweep every element size over lengths 0 to 9. That reaches the partial final element, zero length and the guard bytes past the end. The same setup exercises chaining, cyclic looping, paced bursts and error stops, and the bench predicts each outcome arithmetically.

// File: rtl/dmac_pkg.sv
// Shared constants, state type and command-field decoders for the DMA channel.
// Assumes 32-bit descriptor words and byte addressing.
package dmac_pkg;
    localparam int WORD_W   = 32;
    localparam int LEN_W    = 13;
    localparam int STEP_W   = 3;
    localparam int BURST_W  = 6;
    localparam int REG_AW   = 2;
    localparam int ALIGN_B  = 4;
    localparam int FLAG_N   = 3;

    localparam int CMD_INC_SRC   = 31;
    localparam int CMD_INC_TGT   = 30;
    localparam int CMD_FLOW_SRC  = 29;
    localparam int CMD_FLOW_TGT  = 28;
    localparam int CMD_IRQ_BEGIN = 22;
    localparam int CMD_IRQ_DONE  = 21;
    localparam int CMD_BURST_LO  = 16;
    localparam int CMD_SIZE_LO   = 14;

    localparam int CS_RUN     = 31;
    localparam int CS_PEND    = 8;
    localparam int CS_STOPPED = 3;
    localparam int LINK_STOP  = 0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_BEGIN, ST_GATE, ST_READ, ST_WRITE, ST_FINISH
    } seq_state_t;

    function automatic logic [LEN_W-1:0] cmd_len(input logic [WORD_W-1:0] c);
        return c[LEN_W-1:0];
    endfunction

    function automatic logic [STEP_W-1:0] cmd_elem(input logic [WORD_W-1:0] c);
        case (c[CMD_SIZE_LO +: 2])
            2'd1:    return STEP_W'(1);
            2'd2:    return STEP_W'(2);
            default: return STEP_W'(4);
        endcase
    endfunction

    function automatic logic [BURST_W-1:0] cmd_burst(input logic [WORD_W-1:0] c);
        case (c[CMD_BURST_LO +: 2])
            2'd2:    return BURST_W'(16);
            2'd3:    return BURST_W'(32);
            default: return BURST_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/dmac_status.sv
// Sticky interrupt flags {end, start, bus error}, cleared by write-one.
// Assumes event pulses last one cycle; a set event beats a clear.
module dmac_status
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_err,
    input  logic              ev_begin,
    input  logic              ev_done,
    input  logic              clr_wr,
    input  logic [FLAG_N-1:0] clr_bits,
    output logic [FLAG_N-1:0] flags,
    output logic              irq
);
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] set_v;
    logic [FLAG_N-1:0] clr_v;

    // Collect set and clear masks for this cycle.
    always_comb begin
        set_v = {ev_done, ev_begin, ev_err};
        clr_v = clr_wr ? clr_bits : '0;
    end

    // Update the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_v) | set_v;
    end

    assign flags = flags_q;
    assign irq   = |flags_q;

    generate
        for (genvar i = 0; i < FLAG_N; i++) begin : g_flag_chk
            // R10: a flag only drops after a write-one clear
            assert_w1c_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flags_q[i]) |-> $past(clr_wr && clr_bits[i]));
            // R9: an event leaves its flag set
            assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
                set_v[i] |=> flags_q[i]);
        end
    endgenerate
endmodule

// File: rtl/dmac_burst_gate.sv
// Tracks bytes moved inside the current burst and asks for a peripheral
// request at every burst boundary when pacing is on.
module dmac_burst_gate
    import dmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               advance,
    input  logic [STEP_W-1:0]  step,
    input  logic [BURST_W-1:0] burst_bytes,
    input  logic               flow_en,
    output logic               need_req
);
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W:0]   sum;

    // Bytes after this element.
    always_comb sum = {1'b0, cnt_q} + (BURST_W+1)'(step);

    // Count bytes, wrapping at the burst size.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)             cnt_q <= '0;
        else if (advance) begin
            if (sum >= {1'b0, burst_bytes}) cnt_q <= '0;
            else                            cnt_q <= sum[BURST_W-1:0];
        end
    end

    assign need_req = flow_en && (cnt_q == '0);

    // R8: the count never reaches a full burst
    assert_burst_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart) |=> cnt_q < $past(burst_bytes));
endmodule

// File: rtl/dmac_seq.sv
// Channel sequencer: descriptor fetch, element read/write, address and
// length bookkeeping, chaining and stop control. One access outstanding.
module dmac_seq
    import dmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               halt,
    input  logic               ptr_wr,
    input  logic [WORD_W-1:0]  ptr_wdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WORD_W-1:0]  mem_addr,
    output logic [STEP_W-1:0]  mem_bytes,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_err,
    input  logic               need_req,
    input  logic               periph_req,
    output logic               gate_restart,
    output logic               gate_advance,
    output logic [STEP_W-1:0]  step,
    output logic [BURST_W-1:0] burst_bytes,
    output logic               flow_en,
    output logic               ev_err,
    output logic               ev_begin,
    output logic               ev_done,
    output logic               run,
    output logic               idle,
    output logic [WORD_W-1:0]  ptr,
    output logic [WORD_W-1:0]  src,
    output logic [WORD_W-1:0]  tgt
);
    localparam int LOW_W = $clog2(4 * ALIGN_B);

    seq_state_t        state_q;
    logic [1:0]        idx_q;
    logic [WORD_W-1:0] link_q, cmd_q, src_q, tgt_q, ptr_q, data_q;
    logic [LEN_W-1:0]  remain_q;
    logic              run_q, halt_q;
    logic [STEP_W-1:0] elem;
    logic              acc;

    // Element size and the clamp to the bytes left.
    always_comb begin
        elem = cmd_elem(cmd_q);
        step = (remain_q < LEN_W'(elem)) ? remain_q[STEP_W-1:0] : elem;
    end

    // Memory request decode from the current state.
    always_comb begin
        mem_req   = (state_q == ST_FETCH) || (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_wdata = data_q;
        case (state_q)
            ST_READ:  begin mem_addr = src_q; mem_bytes = step; end
            ST_WRITE: begin mem_addr = tgt_q; mem_bytes = step; end
            default:  begin mem_addr = ptr_q + WORD_W'({idx_q, 2'b00}); mem_bytes = STEP_W'(4); end
        endcase
    end

    assign acc          = mem_req && mem_ack;
    assign ev_err       = acc && mem_err;
    assign ev_begin     = (state_q == ST_BEGIN) && cmd_q[CMD_IRQ_BEGIN];
    assign ev_done      = (state_q == ST_FINISH) && cmd_q[CMD_IRQ_DONE];
    assign gate_restart = (state_q == ST_BEGIN);
    assign gate_advance = (state_q == ST_WRITE) && acc && !mem_err;
    assign flow_en      = cmd_q[CMD_FLOW_SRC] || cmd_q[CMD_FLOW_TGT];
    assign burst_bytes  = cmd_burst(cmd_q);
    assign run  = run_q;
    assign idle = (state_q == ST_IDLE);
    assign ptr  = ptr_q;
    assign src  = src_q;
    assign tgt  = tgt_q;

    // Main sequencer: walks descriptors and moves elements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;  idx_q  <= '0;  link_q <= '0;  cmd_q <= '0;
            src_q   <= '0;       tgt_q  <= '0;  ptr_q  <= '0;  data_q <= '0;
            remain_q <= '0;      run_q  <= 1'b0; halt_q <= 1'b0;
        end else begin
            if (ptr_wr && state_q == ST_IDLE)
                ptr_q <= {ptr_wdata[WORD_W-1:LOW_W], LOW_W'(0)};
            if (halt && state_q != ST_IDLE)
                halt_q <= 1'b1;
            case (state_q)
                ST_IDLE: if (go) begin
                    run_q <= 1'b1;  halt_q <= 1'b0;  idx_q <= '0;  state_q <= ST_FETCH;
                end
                ST_FETCH: if (acc) begin
                    if (mem_err) begin
                        state_q <= ST_IDLE;  run_q <= 1'b0;  halt_q <= 1'b0;
                    end else begin
                        case (idx_q)
                            2'd0:    link_q <= mem_rdata;
                            2'd1:    src_q  <= mem_rdata;
                            2'd2:    tgt_q  <= mem_rdata;
                            default: cmd_q  <= mem_rdata;
                        endcase
                        idx_q <= idx_q + 2'd1;
                        if (idx_q == 2'd3) state_q <= ST_BEGIN;
                    end
                end
                ST_BEGIN: begin
                    remain_q <= cmd_len(cmd_q);
                    state_q  <= ST_GATE;
                end
                ST_GATE: begin
                    if (halt_q) begin
                        state_q <= ST_IDLE;  run_q <= 1'b0;  halt_q <= 1'b0;
                    end else if (remain_q == '0)
                        state_q <= ST_FINISH;
                    else if (!(need_req && !periph_req))
                        state_q <= ST_READ;
                end
                ST_READ: if (acc) begin
                    if (mem_err) begin
                        state_q <= ST_IDLE;  run_q <= 1'b0;  halt_q <= 1'b0;
                    end else begin
                        data_q  <= mem_rdata;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: if (acc) begin
                    if (mem_err) begin
                        state_q <= ST_IDLE;  run_q <= 1'b0;  halt_q <= 1'b0;
                    end else begin
                        if (cmd_q[CMD_INC_SRC]) src_q <= src_q + WORD_W'(step);
                        if (cmd_q[CMD_INC_TGT]) tgt_q <= tgt_q + WORD_W'(step);
                        remain_q <= remain_q - LEN_W'(step);
                        state_q  <= ST_GATE;
                    end
                end
                ST_FINISH: begin
                    if (link_q[LINK_STOP] || halt_q) begin
                        state_q <= ST_IDLE;  run_q <= 1'b0;  halt_q <= 1'b0;
                    end else begin
                        ptr_q   <= {link_q[WORD_W-1:LOW_W], LOW_W'(0)};
                        idx_q   <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: a waiting request keeps its address and direction
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    // R4: a data write never exceeds the bytes left
    assert_write_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_bytes != '0) && (LEN_W'(mem_bytes) <= remain_q));
    // R7: a stop link ends the run after the descriptor
    assert_stop_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH && link_q[LINK_STOP]) |=> !run_q && !mem_req);
    // R11: an error response ends all access
    assert_err_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> !mem_req && !run_q);
endmodule

// File: rtl/dmac_channel.sv
// Top of the DMA channel: register decode and read mux, sequencer, burst
// pacing and interrupt flags. Register reads are combinational.
module dmac_channel
    import dmac_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wen,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [STEP_W-1:0]   mem_bytes,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_err,
    input  logic                periph_req,
    output logic                irq
);
    logic               cs_wr, ptr_wr;
    logic               need_req, gate_restart, gate_advance, flow_en;
    logic [STEP_W-1:0]  step;
    logic [BURST_W-1:0] burst_bytes;
    logic               ev_err, ev_begin, ev_done, run, idle;
    logic [WORD_W-1:0]  ptr, src, tgt, cs_word;
    logic [FLAG_N-1:0]  flags;

    assign ptr_wr = reg_wen && (reg_addr == REG_AW'(0));
    assign cs_wr  = reg_wen && (reg_addr == REG_AW'(1));

    dmac_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .go(cs_wr && reg_wdata[CS_RUN]), .halt(cs_wr && !reg_wdata[CS_RUN]),
        .ptr_wr(ptr_wr), .ptr_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_bytes(mem_bytes), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .need_req(need_req), .periph_req(periph_req),
        .gate_restart(gate_restart), .gate_advance(gate_advance),
        .step(step), .burst_bytes(burst_bytes), .flow_en(flow_en),
        .ev_err(ev_err), .ev_begin(ev_begin), .ev_done(ev_done),
        .run(run), .idle(idle), .ptr(ptr), .src(src), .tgt(tgt)
    );

    dmac_burst_gate u_gate (
        .clk(clk), .rst_n(rst_n), .restart(gate_restart), .advance(gate_advance),
        .step(step), .burst_bytes(burst_bytes), .flow_en(flow_en), .need_req(need_req)
    );

    dmac_status u_status (
        .clk(clk), .rst_n(rst_n), .ev_err(ev_err), .ev_begin(ev_begin),
        .ev_done(ev_done), .clr_wr(cs_wr), .clr_bits(reg_wdata[FLAG_N-1:0]),
        .flags(flags), .irq(irq)
    );

    // Assemble the control/status word.
    always_comb begin
        cs_word               = '0;
        cs_word[CS_RUN]       = run;
        cs_word[CS_PEND]      = periph_req;
        cs_word[CS_STOPPED]   = idle;
        cs_word[FLAG_N-1:0]   = flags;
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            REG_AW'(0): reg_rdata = ptr;
            REG_AW'(1): reg_rdata = cs_word;
            REG_AW'(2): reg_rdata = src;
            default:    reg_rdata = tgt;
        endcase
    end
endmodule

// File: tb/tb_dmac_channel.sv
module tb_dmac_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [2:0]  mem_bytes;
    logic        periph_req = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int wr_total = 0;
    logic [31:0] mem [0:255];
    logic [4:0]  lfsr = 5'h1;
    logic        stall;

    always #10 clk = ~clk;

    dmac_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .periph_req(periph_req), .irq(irq)
    );

    assign stall     = lfsr[0] & lfsr[3];
    assign mem_ack   = mem_req && !stall;
    assign mem_err   = mem_ack && (mem_addr >= 32'h400);
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
        if (mem_req && mem_ack && mem_we && !mem_err) begin
            wr_total <= wr_total + 1;
            for (int b = 0; b < 4; b++)
                if (b >= int'(mem_addr[1:0]) && b < int'(mem_addr[1:0]) + int'(mem_bytes))
                    mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog R1..: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            reg_read(2'd1, v);
            if (v[3]) break;
        end
    endtask

    task automatic put_desc(input int at, input logic [31:0] lk, input logic [31:0] s,
                            input logic [31:0] t, input logic [31:0] c);
        mem[at/4] = lk; mem[at/4+1] = s; mem[at/4+2] = t; mem[at/4+3] = c;
    endtask

    function automatic logic [7:0] byte_at(input int a);
        return mem[a/4][8*(a%4) +: 8];
    endfunction

    task automatic set_byte(input int a, input logic [7:0] v);
        mem[a/4][8*(a%4) +: 8] = v;
    endtask

    task automatic start(input logic [31:0] p);
        reg_write(2'd0, p);
        reg_write(2'd1, 32'h8000_0000);
    endtask

    initial begin
        logic [31:0] v;
        int w0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd1, v); chk(v, 32'h0000_0008, "R1 status after reset");
        chk({31'b0, irq}, 32'h0, "R1 irq after reset");
        chk({31'b0, mem_req}, 32'h0, "R1 mem_req after reset");
        reg_read(2'd0, v); chk(v, 32'h0, "R1 pointer after reset");

        // R2 pointer low bits read zero
        reg_write(2'd0, 32'h0000_0047);
        reg_read(2'd0, v); chk(v, 32'h0000_0040, "R2 pointer alignment");

        // R4 R5 R6 R9: sweep size code 1..3 over lengths 0..9
        for (int w = 1; w <= 3; w++) begin
            for (int len = 0; len <= 9; len++) begin
                int eb;
                eb = (w == 1) ? 1 : (w == 2) ? 2 : 4;
                for (int i = 0; i < 16; i++) begin
                    set_byte(32'h200 + i, 8'((i*13 + len*3 + w) & 255));
                    set_byte(32'h300 + i, 8'hEE);
                end
                put_desc(32'h40, 32'h1, 32'h200, 32'h300,
                         32'hC000_0000 | (32'(w) << 14) | (32'h1 << 21) | 32'(len));
                w0 = wr_total;
                start(32'h40);
                wait_stop();
                for (int i = 0; i < len; i++)
                    chk({24'h0, byte_at(32'h300 + i)}, {24'h0, byte_at(32'h200 + i)}, "R4 copied byte");
                for (int i = len; i < len + 4; i++)
                    chk({24'h0, byte_at(32'h300 + i)}, 32'hEE, "R4 guard byte untouched");
                chk(32'(wr_total - w0), 32'((len + eb - 1) / eb), "R4 element count");
                if (len == 0) chk(32'(wr_total - w0), 32'h0, "R6 zero length no access");
                reg_read(2'd2, v); chk(v, 32'h200 + 32'(len), "R5 final source");
                reg_read(2'd3, v); chk(v, 32'h300 + 32'(len), "R5 final target");
                reg_read(2'd1, v); chk(v, 32'h0000_000C, "R9 end flag, stopped, R7 run clear");
                chk({31'b0, irq}, 32'h1, "R9 irq with end flag");
                reg_write(2'd1, 32'h7);
            end
        end

        // R5 target held, source advances
        for (int i = 0; i < 4; i++) mem[32'h200/4 + i] = 32'hA0A0_0000 + 32'(i);
        mem[32'h300/4] = 0; mem[32'h304/4] = 32'h5555_5555;
        put_desc(32'h40, 32'h1, 32'h200, 32'h300, 32'h8000_C000 | 32'd12);
        start(32'h40); wait_stop();
        chk(mem[32'h300/4], 32'hA0A0_0002, "R5 held target gets last word");
        chk(mem[32'h304/4], 32'h5555_5555, "R5 held target neighbour");
        reg_read(2'd3, v); chk(v, 32'h300, "R5 target register held");
        reg_read(2'd2, v); chk(v, 32'h20C, "R5 source register advanced");
        // R5 source held, target advances
        put_desc(32'h40, 32'h1, 32'h200, 32'h300, 32'h4000_C000 | 32'd8);
        start(32'h40); wait_stop();
        chk(mem[32'h300/4], 32'hA0A0_0000, "R5 held source word 0");
        chk(mem[32'h304/4], 32'hA0A0_0000, "R5 held source word 1");
        reg_read(2'd1, v); chk(v, 32'h0000_0008, "R9 no flags without enables");

        // R7 R9 R3: three-descriptor chain, link low bits ignored
        for (int i = 0; i < 6; i++) mem[32'h200/4 + i] = 32'hC0DE_0000 + 32'(i);
        for (int i = 0; i < 6; i++) mem[32'h300/4 + i] = 32'h0;
        put_desc(32'h40, 32'h5E, 32'h200, 32'h300, 32'hC040_C000 | 32'd8);
        put_desc(32'h50, 32'h60, 32'h208, 32'h308, 32'hC000_C000 | 32'd8);
        put_desc(32'h60, 32'h1, 32'h210, 32'h310, 32'hC020_C000 | 32'd8);
        start(32'h40); wait_stop();
        for (int i = 0; i < 6; i++)
            chk(mem[32'h300/4 + i], 32'hC0DE_0000 + 32'(i), "R7 chained copy");
        reg_read(2'd1, v); chk(v, 32'h0000_000E, "R9 start and end flags after chain");
        reg_read(2'd0, v); chk(v, 32'h60, "R7 pointer on last descriptor");

        // R10 write-one clears only the chosen flag
        reg_write(2'd1, 32'h4);
        reg_read(2'd1, v); chk({29'b0, v[2:0]}, 32'h2, "R10 clear end only");
        chk({31'b0, irq}, 32'h1, "R10 irq held by start flag");
        reg_write(2'd1, 32'h2);
        reg_read(2'd1, v); chk({29'b0, v[2:0]}, 32'h0, "R10 clear start");
        chk({31'b0, irq}, 32'h0, "R10 irq low when clear");

        // R8 R13 paced bursts of 8 bytes, word elements, 16 bytes
        for (int i = 0; i < 4; i++) mem[32'h300/4 + i] = 32'h0;
        put_desc(32'h40, 32'h1, 32'h200, 32'h300, 32'hE001_C000 | 32'd16);
        w0 = wr_total;
        start(32'h40);
        repeat (30) @(negedge clk);
        chk(32'(wr_total - w0), 32'h0, "R8 no access without request");
        reg_read(2'd2, v); chk(v, 32'h200, "R13 source before request");
        reg_read(2'd1, v); chk({23'b0, v[8:0]} & 32'h100, 32'h0, "R8 pending bit low");
        @(negedge clk); periph_req = 1'b1;
        #1 chk({31'b0, reg_rdata[8]} , 32'h1, "R8 pending bit high");
        @(negedge clk); periph_req = 1'b0;
        repeat (30) @(negedge clk);
        chk(32'(wr_total - w0), 32'h2, "R8 one burst of two words");
        reg_read(2'd2, v); chk(v, 32'h208, "R13 source mid transfer");
        reg_read(2'd3, v); chk(v, 32'h308, "R13 target mid transfer");
        reg_read(2'd1, v); chk({31'b0, v[31]}, 32'h1, "R8 still running");
        @(negedge clk); periph_req = 1'b1;
        @(negedge clk); periph_req = 1'b0;
        wait_stop();
        chk(32'(wr_total - w0), 32'h4, "R8 second burst completes");

        // R11 error on data read and on descriptor fetch
        put_desc(32'h40, 32'h1, 32'h800, 32'h300, 32'hC000_C000 | 32'd8);
        w0 = wr_total;
        start(32'h40); wait_stop();
        reg_read(2'd1, v); chk(v, 32'h0000_0009, "R11 error flag, stopped");
        chk(32'(wr_total - w0), 32'h0, "R11 no write after error");
        chk({31'b0, irq}, 32'h1, "R11 irq on error");
        reg_write(2'd1, 32'h1);
        start(32'h800); wait_stop();
        reg_read(2'd1, v); chk(v, 32'h0000_0009, "R11 fetch error flag");
        reg_write(2'd1, 32'h1);

        // R7 R12 R2: cyclic loop, ignored pointer write, software stop
        put_desc(32'h80, 32'h90, 32'h200, 32'h300, 32'hC020_C000 | 32'd8);
        put_desc(32'h90, 32'h80, 32'h208, 32'h308, 32'hC020_C000 | 32'd8);
        w0 = wr_total;
        start(32'h80);
        repeat (200) @(negedge clk);
        reg_read(2'd1, v); chk({v[31], 27'b0, v[3:0] & 4'h8}, 32'h8000_0000, "R7 cyclic still running");
        chk(32'(wr_total - w0 > 8), 32'h1, "R7 cyclic made several passes");
        reg_write(2'd0, 32'h0F0);
        reg_read(2'd0, v); chk(32'(v == 32'h80 || v == 32'h90), 32'h1, "R2 pointer write ignored while running");
        reg_write(2'd1, 32'h8000_0004);
        reg_read(2'd1, v); chk({31'b0, v[31]}, 32'h1, "R12 flag clear with run set keeps running");
        reg_write(2'd1, 32'h0);
        wait_stop();
        reg_read(2'd1, v); chk({31'b0, v[31]}, 32'h0, "R12 run clear after stop");
        w0 = wr_total;
        repeat (50) @(negedge clk);
        chk(32'(wr_total - w0), 32'h0, "R12 no access after stop");
        chk({31'b0, mem_req}, 32'h0, "R12 mem_req low after stop");

        summary();
        $finish;
    end
endmodule